// File: doc/BRIEF.md
# Read Sampling Point Calibrator

This block finds a sampling point for serial read data coming back from a far device. It reaches that device only through a register access port. Each access carries an address, a write flag and write data, and the read data comes back on a response. The block first walks a local coarse sampling-edge setting upward. It stops at the lowest setting where a fixed test register on the far device returns its known constant.

Next it programs a delay register on the far device, starting at zero. At each delay it loops a fixed sequence of thirty test words through a scratch register. It raises the delay until the first word fails to come back intact, which marks the leading boundary of the data window. It then advances the coarse edge by one more step so that sampling sits inside the window, and it checks that choice with one last read of the test register.

The outputs are the coarse control word, the far-end delay it settled on, and a two-bit result code. The result code is held until the next start.

Top module: `rx_samp_cal`

## Requirements
- R1: After reset `busy_o`, `done_o`, `req_valid_o` and `sample_ctrl_o` are 0. A start clears the coarse edge to 0, and `sample_ctrl_o` always equals the coarse edge shifted left by 5 bits.
- R2: Each coarse step issues one read of address `RTEST_ADDR` (default 0x0040). The sweep stops at the first step whose read data equals `RTEST_VAL` (default 0xC35A).
- R3: When none of the edges 0..15 matches, the run ends with result code 1, and the edge stays at 15.
- R4: When the first match is at edge 15, the run ends with result code 2 and the edge at 15. No delay write and no final read are issued.
- R5: For delay d = 0, 1, ... the block writes d to address `DLY_ADDR` (default 0x0050). It then makes 30 pairs of accesses to address `WTEST_ADDR` (default 0x0042), each a write of a test word followed by a read.
- R6: The 30 test words are, by index i: for i<10, 0x6996 when i is even and 0x9669 when odd; for 10≤i<20, 0x5AA5 when i is even and 0xA55A when odd; for 20≤i<30, 0x1B27.
- R7: A readback mismatches only when its low 15 bits differ from the word written, so bit 15 is ignored. The first mismatch ends the delay sweep, and `far_dly_o` keeps that delay.
- R8: When all 30 words pass at every delay 0..9, the delay sweep ends at delay 9.
- R9: After the delay sweep the edge advances by one and `RTEST_ADDR` is read once more. The result code is 0 if the read returns `RTEST_VAL`, and 3 otherwise.
- R10: A request holds `req_valid_o`, address, write flag and data steady until `req_ready_i`. Only one access is outstanding at a time, and a response is taken only in a cycle after the request was accepted.
- R11: `done_o` stays high with a stable result and stable settings until the next start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a calibration run (taken when not busy) |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Run finished; result valid |
| result_o | output | 2 | 0 ok, 1 no edge, 2 last edge, 3 final read failed |
| sample_ctrl_o | output | 9 | Coarse edge shifted left by 5 |
| far_dly_o | output | 4 | Far-end delay setting reached |
| req_valid_o | output | 1 | Access request valid |
| req_ready_i | input | 1 | Access request accepted |
| req_we_o | output | 1 | 1 write, 0 read |
| req_addr_o | output | 16 | Access address |
| req_wdata_o | output | 16 | Write data |
| rsp_valid_i | input | 1 | Access response valid |
| rsp_rdata_i | input | 16 | Read data of the response |

## Verification
A far-device model answers the test register correctly only inside a window of coarse edges, and the bench sweeps the window's low edge across all sixteen settings. This separates the first-match search, the last-edge failure and the no-edge failure. A second sweep moves the delay at which loopback corrupts bit 0 from 0 up to "never". This tells an early boundary apart from a late one and from the saturated delay 9. The count and order of delay writes and test words are checked on every run. Other runs flip only bit 15, which must be ignored. A window one edge wide must produce the final-read failure. Request stalls of several lengths exercise the handshake.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
  typedef enum logic [1:0] {
    RES_OK        = 2'd0,
    RES_NO_EDGE   = 2'd1,
    RES_LAST_EDGE = 2'd2,
    RES_READ_FAIL = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EDGE_RD, ST_DLY_WR, ST_PAT_WR,
    ST_PAT_RD, ST_EDGE_STEP, ST_FINAL_RD, ST_DONE
  } cal_st_e;

  typedef enum logic [1:0] {PH_IDLE, PH_REQ, PH_WAIT} bus_ph_e;
endpackage

// File: rtl/rsc_pattern.sv
`timescale 1ns/1ps
module rsc_pattern #(
  parameter int DATA_W = 16,
  parameter int REP    = 10,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] B1 = IDX_W'(REP);
  localparam logic [IDX_W-1:0] B2 = IDX_W'(2*REP);

  logic odd;
  always_comb begin
    if (idx_i < B1) begin
      odd    = idx_i[0];
      word_o = odd ? DATA_W'(16'h9669) : DATA_W'(16'h6996);
    end else if (idx_i < B2) begin
      odd    = 1'(idx_i - B1);
      word_o = odd ? DATA_W'(16'hA55A) : DATA_W'(16'h5AA5);
    end else begin
      odd    = 1'b0;
      word_o = DATA_W'(16'h1B27);
    end
  end
endmodule

// File: rtl/rsc_bus_master.sv
`timescale 1ns/1ps
module rsc_bus_master
  import rsc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  bus_ph_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      req_we_o    <= 1'b0;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
      done_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: if (go_i) begin
          req_we_o    <= we_i;
          req_addr_o  <= addr_i;
          req_wdata_o <= wdata_i;
          ph_q        <= PH_REQ;
        end
        PH_REQ:  if (req_ready_i) ph_q <= PH_WAIT;
        PH_WAIT: if (rsp_valid_i) begin
          rdata_o <= rsp_rdata_i;
          done_o  <= 1'b1;
          ph_q    <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign req_valid_o = (ph_q == PH_REQ);
endmodule

// File: rtl/rx_samp_cal.sv
`timescale 1ns/1ps
module rx_samp_cal
  import rsc_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 16,
  parameter int              EDGE_W     = 4,
  parameter int              EDGE_SHIFT = 5,
  parameter int              DLY_STEPS  = 10,
  parameter int              PAT_REP    = 10,
  parameter int              CMP_BITS   = 15,
  parameter logic [15:0]     RTEST_ADDR = 16'h0040,
  parameter logic [15:0]     RTEST_VAL  = 16'hC35A,
  parameter logic [15:0]     WTEST_ADDR = 16'h0042,
  parameter logic [15:0]     DLY_ADDR   = 16'h0050,
  localparam int             CTRL_W     = EDGE_W + EDGE_SHIFT,
  localparam int             DLY_W      = $clog2(DLY_STEPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [CTRL_W-1:0] sample_ctrl_o,
  output logic [DLY_W-1:0]  far_dly_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_we_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i
);
  localparam int                PAT_N    = 3 * PAT_REP;
  localparam int                IDX_W    = $clog2(PAT_N);
  localparam logic [EDGE_W-1:0] EDGE_MAX = '1;
  localparam logic [DLY_W-1:0]  DLY_LAST = DLY_W'(DLY_STEPS - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(PAT_N - 1);
  localparam logic [DATA_W-1:0] CMP_MASK = DATA_W'({CMP_BITS{1'b1}});

  cal_st_e           st_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DLY_W-1:0]  dly_q;
  logic [IDX_W-1:0]  idx_q;
  logic              issued_q;
  res_e              res_q;

  logic              acc, go, we, bus_done;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, pat_word, bus_rdata;
  logic              rd_ok, pat_ok;

  rsc_pattern #(.DATA_W(DATA_W), .REP(PAT_REP), .IDX_W(IDX_W)) u_pat (
    .idx_i (idx_q),
    .word_o(pat_word)
  );

  always_comb begin
    acc   = 1'b0;
    we    = 1'b0;
    addr  = ADDR_W'(RTEST_ADDR);
    wdata = '0;
    case (st_q)
      ST_EDGE_RD, ST_FINAL_RD: acc = 1'b1;
      ST_DLY_WR: begin
        acc = 1'b1; we = 1'b1; addr = ADDR_W'(DLY_ADDR); wdata = DATA_W'(dly_q);
      end
      ST_PAT_WR: begin
        acc = 1'b1; we = 1'b1; addr = ADDR_W'(WTEST_ADDR); wdata = pat_word;
      end
      ST_PAT_RD: begin
        acc = 1'b1; addr = ADDR_W'(WTEST_ADDR);
      end
      default: ;
    endcase
  end

  assign go = acc && !issued_q;

  rsc_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i, .rst_ni,
    .go_i       (go),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .req_valid_o, .req_ready_i, .req_we_o, .req_addr_o, .req_wdata_o,
    .rsp_valid_i, .rsp_rdata_i,
    .done_o     (bus_done),
    .rdata_o    (bus_rdata)
  );

  assign rd_ok  = (bus_rdata == DATA_W'(RTEST_VAL));
  assign pat_ok = ((bus_rdata ^ pat_word) & CMP_MASK) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      edge_q   <= '0;
      dly_q    <= '0;
      idx_q    <= '0;
      issued_q <= 1'b0;
      res_q    <= RES_OK;
    end else begin
      if (go)       issued_q <= 1'b1;
      if (bus_done) issued_q <= 1'b0;
      case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          edge_q <= '0;
          dly_q  <= '0;
          idx_q  <= '0;
          res_q  <= RES_OK;
          st_q   <= ST_EDGE_RD;
        end
        ST_EDGE_RD: if (bus_done) begin
          if (rd_ok) begin
            if (edge_q == EDGE_MAX) begin
              res_q <= RES_LAST_EDGE;
              st_q  <= ST_DONE;
            end else begin
              st_q <= ST_DLY_WR;
            end
          end else if (edge_q == EDGE_MAX) begin
            res_q <= RES_NO_EDGE;
            st_q  <= ST_DONE;
          end else begin
            edge_q <= edge_q + 1'b1;
          end
        end
        ST_DLY_WR: if (bus_done) begin
          idx_q <= '0;
          st_q  <= ST_PAT_WR;
        end
        ST_PAT_WR: if (bus_done) st_q <= ST_PAT_RD;
        ST_PAT_RD: if (bus_done) begin
          if (!pat_ok) begin
            st_q <= ST_EDGE_STEP;
          end else if (idx_q == IDX_LAST) begin
            if (dly_q == DLY_LAST) begin
              st_q <= ST_EDGE_STEP;
            end else begin
              dly_q <= dly_q + 1'b1;
              st_q  <= ST_DLY_WR;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_PAT_WR;
          end
        end
        ST_EDGE_STEP: begin
          edge_q <= edge_q + 1'b1;
          st_q   <= ST_FINAL_RD;
        end
        ST_FINAL_RD: if (bus_done) begin
          res_q <= rd_ok ? RES_OK : RES_READ_FAIL;
          st_q  <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o        = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done_o        = (st_q == ST_DONE);
  assign result_o      = res_q;
  assign sample_ctrl_o = {edge_q, EDGE_SHIFT'(0)};
  assign far_dly_o     = dly_q;
endmodule

// File: rtl/rx_samp_cal_chk.sv
`timescale 1ns/1ps
module rx_samp_cal_chk #(
  parameter int              CTRL_W   = 9,
  parameter int              DLY_W    = 4,
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 16,
  parameter logic [CTRL_W-1:0] CTRL_MAX = '0,
  parameter logic [DLY_W-1:0]  DLY_MAX  = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [1:0]        result_o,
  input logic [CTRL_W-1:0] sample_ctrl_o,
  input logic [DLY_W-1:0]  far_dly_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_we_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o
);
  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_wdata_o) && $stable(req_we_o));

  a_r10_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  a_r11_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(result_o) && $stable(sample_ctrl_o)
      && $stable(far_dly_o));

  a_r1_edge_climbs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> sample_ctrl_o >= $past(sample_ctrl_o));

  a_r3_no_edge_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && result_o == 2'd1 |-> sample_ctrl_o == CTRL_MAX);

  a_r4_last_edge_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && result_o == 2'd2 |-> sample_ctrl_o == CTRL_MAX && far_dly_o == '0);

  a_r9_ok_after_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && result_o == 2'd0 |-> sample_ctrl_o != '0);

  a_r8_dly_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_dly_o <= DLY_MAX);
endmodule

bind rx_samp_cal rx_samp_cal_chk #(
  .CTRL_W  (CTRL_W),
  .DLY_W   (DLY_W),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .CTRL_MAX({EDGE_MAX, EDGE_SHIFT'(0)}),
  .DLY_MAX (DLY_LAST)
) u_chk (
  .clk_i, .rst_ni, .start_i, .busy_o, .done_o, .result_o, .sample_ctrl_o,
  .far_dly_o, .req_valid_o, .req_ready_i, .req_we_o, .req_addr_o, .req_wdata_o
);

// File: tb/tb_rx_samp_cal.sv
`timescale 1ns/1ps
module tb_rx_samp_cal;
  localparam logic [15:0] RT_A = 16'h0040;
  localparam logic [15:0] RT_V = 16'hC35A;
  localparam logic [15:0] WT_A = 16'h0042;
  localparam logic [15:0] DL_A = 16'h0050;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done;
  logic [1:0]  result;
  logic [8:0]  sctrl;
  logic [3:0]  fdly;
  logic        req_valid, req_ready = 1'b0, req_we;
  logic [15:0] req_addr, req_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  always #2 clk = ~clk;

  rx_samp_cal dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .result_o(result), .sample_ctrl_o(sctrl), .far_dly_o(fdly),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_we_o(req_we),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata),
    .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata)
  );

  int checks = 0, fails = 0;
  // far-device model knobs
  int e_lo = 99, e_hi = 99, d_fail = 99, stall = 0;
  bit flip15 = 0;
  // far-device state and observation counters
  logic [15:0] dev_dly = '0, dev_wt = '0;
  int n_rt = 0, n_dw = 0, n_pw = 0, pat_i = 0, seq_err = 0;

  function automatic logic [15:0] exp_pat(int i);
    if (i < 10) return (i % 2) ? 16'h9669 : 16'h6996;
    if (i < 20) return ((i - 10) % 2) ? 16'hA55A : 16'h5AA5;
    return 16'h1B27;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // responder
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic        w;
        logic [15:0] a, d, r;
        int          e;
        repeat (stall) @(negedge clk);
        req_ready = 1'b1;
        w = req_we; a = req_addr; d = req_wdata; e = int'(sctrl >> 5);
        @(negedge clk);
        req_ready = 1'b0;
        r = '0;
        if (w) begin
          if (a == DL_A) begin
            if (int'(d) != n_dw) seq_err++;
            dev_dly = d; n_dw++; pat_i = 0;
          end else if (a == WT_A) begin
            if (d != exp_pat(pat_i)) seq_err++;
            dev_wt = d; n_pw++; pat_i++;
          end else seq_err++;
        end else if (a == RT_A) begin
          n_rt++;
          r = (e >= e_lo && e <= e_hi) ? RT_V : (RT_V ^ 16'h0101);
        end else if (a == WT_A) begin
          r = dev_wt;
          if (flip15) r = r ^ 16'h8000;
          if (int'(dev_dly) >= d_fail) r = r ^ 16'h0001;
        end else seq_err++;
        rsp_rdata = r;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  task automatic run_case(int lo, int hi, int df, bit f15, int st, bit restart_mid);
    int x_res, x_edge, x_dly, x_dw, x_pw, x_rt, dfin;
    e_lo = lo; e_hi = hi; d_fail = df; flip15 = f15; stall = st;
    n_rt = 0; n_dw = 0; n_pw = 0; pat_i = 0; seq_err = 0; dev_dly = '0;
    if (lo > 15) begin
      x_res = 1; x_edge = 15; x_dly = 0; x_dw = 0; x_pw = 0; x_rt = 16;
    end else if (lo == 15) begin
      x_res = 2; x_edge = 15; x_dly = 0; x_dw = 0; x_pw = 0; x_rt = 16;
    end else begin
      dfin   = (df <= 9) ? df : 9;
      x_dly  = dfin;
      x_dw   = dfin + 1;
      x_pw   = dfin * 30 + ((df <= 9) ? 1 : 30);
      x_edge = lo + 1;
      x_rt   = lo + 2;
      x_res  = (lo + 1 <= hi) ? 0 : 3;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (restart_mid) begin
      repeat (25) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk("R2/R3/R4/R9 result", int'(result), x_res);
    chk("R1 sample_ctrl", int'(sctrl), x_edge << 5);
    chk("R7/R8 far_dly", int'(fdly), x_dly);
    chk("R2 test reads", n_rt, x_rt);
    chk("R5 delay writes", n_dw, x_dw);
    chk("R5 pattern writes", n_pw, x_pw);
    chk("R6 word/delay order", seq_err, 0);
    repeat (3) @(negedge clk);
    chk("R11 done held", int'(done), 1);
    chk("R11 result held", int'(result), x_res);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset req_valid", int'(req_valid), 0);
    chk("R1 reset sample_ctrl", int'(sctrl), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2/R4: low edge of window across every setting
    for (int lo = 0; lo < 16; lo++)
      run_case(lo, (lo + 3 > 15) ? 15 : lo + 3, 3, 1'b0, lo % 3, 1'b0);
    // R3: no edge at all
    run_case(99, 99, 3, 1'b0, 1, 1'b0);
    // R7/R8: boundary delay from 0 to never
    for (int df = 0; df <= 10; df++)
      run_case(2, 6, (df == 10) ? 99 : df, 1'b0, df % 2, 1'b0);
    // R7: bit 15 flips ignored
    run_case(5, 9, 99, 1'b1, 0, 1'b0);
    run_case(1, 4, 4, 1'b1, 2, 1'b0);
    // R9: window one edge wide
    run_case(4, 4, 2, 1'b0, 0, 1'b0);
    // R11: start while busy ignored
    run_case(3, 7, 1, 1'b0, 1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule